// File: doc/BRIEF.md
# Lookup-Table Refill Engine

The block rewrites a two-dimensional address-translation lookup table from a linked chain of descriptors kept in memory. Software writes the address of the first descriptor into the pointer register. The engine then reads the five words of that descriptor: the rectangle corners, a control word, the next-descriptor pointer and the data-array pointer. It reads one 32-bit page address for every slot of the rectangle and writes each one into the table. When the pointer to the next descriptor is zero, the walk stops and the engine raises its completion interrupt. A zero written to the pointer register abandons a refill that is in progress.

The block has four interfaces: a request/acknowledge memory read port with one read outstanding, a single-cycle table write port, a word-addressed register port and one interrupt line. The interrupt status of the engine sits in its own 8-bit lane of a 32-bit register. The `LANE` parameter selects that lane, so several engines can share one status word.

The sequencer has six states: `S_IDLE`, `S_DESC_RD`, `S_CHECK`, `S_DATA_RD`, `S_LUT_WR` and `S_DESC_END`. Its transitions are:
- **start**: `S_IDLE` to `S_DESC_RD`.
- **word step**: `S_DESC_RD` to itself while fewer than five words have been read.
- **descriptor loaded**: `S_DESC_RD` to `S_CHECK`.
- **reject**: `S_CHECK` to `S_IDLE`.
- **skip**: `S_CHECK` to `S_DESC_END` when the start bit is clear.
- **walk**: `S_CHECK` to `S_DATA_RD`.
- **entry fetched**: `S_DATA_RD` to `S_LUT_WR`.
- **next slot**: `S_LUT_WR` to `S_DATA_RD`.
- **rectangle done**: `S_LUT_WR` to `S_DESC_END`.
- **follow**: `S_DESC_END` to `S_DESC_RD`.
- **finish or bad link**: `S_DESC_END` to `S_IDLE`.
- **read fault**: either read state to `S_IDLE`.
- **abort**: any state to `S_IDLE`.

Top module: `lut_refill_engine`

## Requirements
- R1: After reset:
  - the status reads 0x1 (ready only);
  - the interrupt lane and the enables read 0;
  - `irq`, `mem_req` and `lut_we` are low.
- R2: Registers are selected by the word index on `reg_addr`:
  - 0: descriptor pointer, read back as the last accepted pointer.
  - 1: status, with bit 0 ready, bit 1 valid, bit 2 done and bit 3 error.
  - 2: interrupt status.
  - 3: enable set.
  - 4: enable clear.
  - Reading index 3 or 4 returns the enables.
- R3: A write of a nonzero pointer with bits [3:0] zero, made while ready, starts a refill. On the next cycle ready is low and `mem_req` is high with `mem_addr` equal to the pointer. The descriptor words are then read at pointer+0, +4, +8, +12 and +16, in that order.
- R4: The descriptor words are laid out as follows:
  - Word 0 is {y0[15:0], x0[15:0]}.
  - Word 1 is {y1, x1}.
  - Word 2 is the control word: bit 0 is start and bits [7:4] are the table id.
  - Word 3 is the next pointer.
  - Word 4 is the data pointer.
- R5: Entry k is read from data pointer + 4k. The entries are written in row-major order over the rectangle, with x varying fastest. Each write uses `lut_addr` = y*LUT_WIDTH + x, `lut_wdata` = the entry and `lut_id` = the id from the control word.
- R6: A nonzero next pointer is followed. A zero next pointer ends the chain. The status then reads 0x7 (ready, valid, done) and lane bit 4 (last descriptor) is set.
- R7: Every descriptor that finishes without error sets lane bit 7, including a skipped descriptor.
- R8: A descriptor with the start bit clear makes no table writes, and the chain continues.
- R9: A write of zero to the pointer register does the following:
  - It aborts the refill at once.
  - From the next cycle, no memory read or table write is made.
  - The status reads 0x1.
  - The pointer reads back 0.
- R10: A nonzero pointer write while busy is ignored. The pointer readback and the running chain are unchanged.
- R11: Any of the following sets the error bit and lane bit 1, then stops the chain with ready set (status 0x9):
  - a start pointer or next pointer with bits [3:0] nonzero;
  - a rectangle with x1<x0 or y1<y0;
  - a rectangle corner outside the table;
  - a data pointer with bits [1:0] nonzero.
- R12: A memory read answered with `mem_err` sets the error bit and lane bit 2 and stops the chain. Table writes already made remain.
- R13: The engine's interrupt bits are at register bits [8*LANE+7:8*LANE]; other bits read 0.
  - Writing 1s to the interrupt status clears the matching lane bits. Writes to other lanes have no effect.
  - The enables are set and cleared through their own registers.
  - `irq` is high while any enabled lane bit is set.
  - Bit 0 (advisory miss) is never set by this engine.
- R14: While `mem_req` is high without `mem_ack`, the request and `mem_addr` hold. Every read address is word aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read failed, qualified by mem_ack |
| lut_we | output | 1 | Table write strobe |
| lut_addr | output | LUT_AW | Table slot index |
| lut_wdata | output | 32 | Page address written |
| lut_id | output | 4 | Target table id |
| irq | output | 1 | Interrupt |

## Verification
The hardest situations to reach from the ports are these:
- an abort that lands while a data read is outstanding, partway through a long rectangle;
- a read fault on one chosen entry in the middle of a walk.

The bench's memory model answers every read one cycle after the request, and it can flag one selected address as faulty. The bench counts cycles after the start before writing zero, and it checks that table writes have begun but have not completed. A chain that mixes a skipped descriptor with a single-slot rectangle in the far corner of the table covers both the link-following path and the highest table address.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DESC_RD,
        S_CHECK,
        S_DATA_RD,
        S_LUT_WR,
        S_DESC_END
    } seq_state_t;

    // Bit positions inside the engine's interrupt lane
    localparam int IRQ_MISS     = 0;
    localparam int IRQ_DESC_ERR = 1;
    localparam int IRQ_MEM_ERR  = 2;
    localparam int IRQ_LAST     = 4;
    localparam int IRQ_FILL     = 7;

    // Register word indices
    localparam logic [2:0] RA_DESC   = 3'd0;
    localparam logic [2:0] RA_STAT   = 3'd1;
    localparam logic [2:0] RA_IRQ    = 3'd2;
    localparam logic [2:0] RA_EN_SET = 3'd3;
    localparam logic [2:0] RA_EN_CLR = 3'd4;

    localparam int DESC_WORDS = 5;

    typedef struct packed {
        logic fill;
        logic last;
        logic desc_err;
        logic mem_err;
    } seq_evt_t;

endpackage

// File: rtl/lrf_walker.sv
module lrf_walker #(
    parameter  int LUT_WIDTH  = 16,
    parameter  int LUT_HEIGHT = 8,
    localparam int X_W = $clog2(LUT_WIDTH),
    localparam int Y_W = $clog2(LUT_HEIGHT),
    localparam int AW  = $clog2(LUT_WIDTH * LUT_HEIGHT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [X_W-1:0] x0_i,
    input  logic [Y_W-1:0] y0_i,
    input  logic [X_W-1:0] x1_i,
    input  logic [Y_W-1:0] y1_i,
    output logic           last_o,
    output logic [AW-1:0]  addr_o
);

    logic [X_W-1:0] x_q;
    logic [Y_W-1:0] y_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load_i) begin
            x_q <= x0_i;
            y_q <= y0_i;
        end else if (step_i) begin
            if (x_q == x1_i) begin
                x_q <= x0_i;
                y_q <= y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    assign last_o = (x_q == x1_i) && (y_q == y1_i);

    // A power-of-two row width turns the row-major index into a concatenation
    generate
        if ((LUT_WIDTH & (LUT_WIDTH - 1)) == 0) begin : g_pow2
            assign addr_o = AW'({y_q, x_q});
        end else begin : g_mul
            assign addr_o = AW'(int'(y_q) * LUT_WIDTH + int'(x_q));
        end
    endgenerate

endmodule

// File: rtl/lrf_seq.sv
module lrf_seq
    import lrf_pkg::*;
#(
    parameter  int LUT_WIDTH  = 16,
    parameter  int LUT_HEIGHT = 8,
    localparam int X_W = $clog2(LUT_WIDTH),
    localparam int Y_W = $clog2(LUT_HEIGHT),
    localparam int AW  = $clog2(LUT_WIDTH * LUT_HEIGHT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   start_ptr_i,
    input  logic          abort_i,
    output logic          mem_req_o,
    output logic [31:0]   mem_addr_o,
    input  logic          mem_ack_i,
    input  logic [31:0]   mem_rdata_i,
    input  logic          mem_err_i,
    output logic          lut_we_o,
    output logic [AW-1:0] lut_addr_o,
    output logic [31:0]   lut_wdata_o,
    output logic [3:0]    lut_id_o,
    output logic          busy_o,
    output seq_evt_t      evt_o
);

    seq_state_t  st_q, st_d;

    logic [31:0] base_q;
    logic [2:0]  widx_q;
    logic [15:0] x0_q, y0_q, x1_q, y1_q;
    logic        go_q;
    logic [3:0]  id_q;
    logic [31:0] next_q, dptr_q, daddr_q, data_q;
    logic        rect_bad, link_bad, last_slot, ack_ok;

    assign rect_bad = (x1_q < x0_q) || (y1_q < y0_q) ||
                      (x1_q >= 16'(LUT_WIDTH)) || (y1_q >= 16'(LUT_HEIGHT)) ||
                      (dptr_q[1:0] != 2'b00);
    assign link_bad = (next_q != '0) && (next_q[3:0] != 4'h0);
    assign ack_ok   = mem_ack_i && !mem_err_i;

    lrf_walker #(
        .LUT_WIDTH (LUT_WIDTH),
        .LUT_HEIGHT(LUT_HEIGHT)
    ) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(st_q == S_CHECK),
        .step_i((st_q == S_LUT_WR) && !last_slot),
        .x0_i  (x0_q[X_W-1:0]),
        .y0_i  (y0_q[Y_W-1:0]),
        .x1_i  (x1_q[X_W-1:0]),
        .y1_i  (y1_q[Y_W-1:0]),
        .last_o(last_slot),
        .addr_o(lut_addr_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        if (abort_i) begin
            st_d = S_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE:     if (start_i) st_d = S_DESC_RD;
                S_DESC_RD:  if (mem_ack_i) begin
                                if (mem_err_i)                      st_d = S_IDLE;
                                else if (widx_q == 3'(DESC_WORDS-1)) st_d = S_CHECK;
                            end
                S_CHECK:    if (rect_bad)  st_d = S_IDLE;
                            else if (go_q) st_d = S_DATA_RD;
                            else           st_d = S_DESC_END;
                S_DATA_RD:  if (mem_ack_i) st_d = mem_err_i ? S_IDLE : S_LUT_WR;
                S_LUT_WR:   st_d = last_slot ? S_DESC_END : S_DATA_RD;
                S_DESC_END: st_d = (next_q == '0 || link_bad) ? S_IDLE : S_DESC_RD;
                default:    st_d = S_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            widx_q  <= '0;
            x0_q    <= '0;
            y0_q    <= '0;
            x1_q    <= '0;
            y1_q    <= '0;
            go_q    <= 1'b0;
            id_q    <= '0;
            next_q  <= '0;
            dptr_q  <= '0;
            daddr_q <= '0;
            data_q  <= '0;
        end else if (!abort_i) begin
            unique case (st_q)
                S_IDLE: if (start_i) begin
                    base_q <= start_ptr_i;
                    widx_q <= '0;
                end
                S_DESC_RD: if (ack_ok) begin
                    unique case (widx_q)
                        3'd0: begin x0_q <= mem_rdata_i[15:0]; y0_q <= mem_rdata_i[31:16]; end
                        3'd1: begin x1_q <= mem_rdata_i[15:0]; y1_q <= mem_rdata_i[31:16]; end
                        3'd2: begin go_q <= mem_rdata_i[0];    id_q <= mem_rdata_i[7:4];   end
                        3'd3: next_q <= mem_rdata_i;
                        3'd4: dptr_q <= mem_rdata_i;
                        default: ;
                    endcase
                    widx_q <= widx_q + 1'b1;
                end
                S_CHECK:   daddr_q <= dptr_q;
                S_DATA_RD: if (ack_ok) data_q <= mem_rdata_i;
                S_LUT_WR:  daddr_q <= daddr_q + 32'd4;
                S_DESC_END: if (next_q != '0 && !link_bad) begin
                    base_q <= next_q;
                    widx_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req_o      = 1'b0;
        mem_addr_o     = daddr_q;
        lut_we_o       = 1'b0;
        evt_o          = '0;
        unique case (st_q)
            S_DESC_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = base_q + {27'b0, widx_q, 2'b00};
                evt_o.mem_err = mem_ack_i && mem_err_i && !abort_i;
            end
            S_DATA_RD: begin
                mem_req_o  = 1'b1;
                evt_o.mem_err = mem_ack_i && mem_err_i && !abort_i;
            end
            S_CHECK:    evt_o.desc_err = rect_bad && !abort_i;
            S_LUT_WR:   lut_we_o = !abort_i;
            S_DESC_END: begin
                evt_o.fill     = !abort_i;
                evt_o.last     = (next_q == '0) && !abort_i;
                evt_o.desc_err = link_bad && !abort_i;
            end
            default: ;
        endcase
    end

    assign lut_wdata_o = data_q;
    assign lut_id_o    = id_q;
    assign busy_o      = (st_q != S_IDLE);

endmodule

// File: rtl/lrf_regs.sv
module lrf_regs
    import lrf_pkg::*;
#(
    parameter  int LANE   = 0,
    localparam int LANE_LO = 8 * LANE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy_i,
    input  seq_evt_t    evt_i,
    output logic        start_o,
    output logic [31:0] start_ptr_o,
    output logic        abort_o,
    output logic        irq_o
);

    logic [31:0] desc_q;
    logic        valid_q, done_q, err_q;
    logic [7:0]  lane_q, en_q, lane_set, lane_clr;
    logic        desc_wr, bad_start, restart;

    assign desc_wr     = reg_we && (reg_addr == RA_DESC);
    assign abort_o     = desc_wr && (reg_wdata == '0);
    assign start_o     = desc_wr && (reg_wdata != '0) && (reg_wdata[3:0] == 4'h0) && !busy_i;
    assign bad_start   = desc_wr && (reg_wdata != '0) && (reg_wdata[3:0] != 4'h0) && !busy_i;
    assign start_ptr_o = reg_wdata;
    assign restart     = start_o || abort_o || bad_start;

    always_comb begin
        lane_set               = '0;
        lane_set[IRQ_FILL]     = evt_i.fill;
        lane_set[IRQ_LAST]     = evt_i.last;
        lane_set[IRQ_DESC_ERR] = evt_i.desc_err || bad_start;
        lane_set[IRQ_MEM_ERR]  = evt_i.mem_err;
        lane_clr = (reg_we && reg_addr == RA_IRQ) ? reg_wdata[LANE_LO +: 8] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            lane_q  <= '0;
            en_q    <= '0;
        end else begin
            if (start_o || abort_o) desc_q <= reg_wdata;
            if (restart) begin
                valid_q <= 1'b0;
                done_q  <= 1'b0;
                err_q   <= bad_start;
            end else begin
                if (evt_i.last) begin
                    valid_q <= 1'b1;
                    done_q  <= 1'b1;
                end
                if (evt_i.desc_err || evt_i.mem_err) err_q <= 1'b1;
            end
            lane_q <= (lane_q & ~lane_clr) | lane_set;
            if (reg_we && reg_addr == RA_EN_SET) en_q <= en_q | reg_wdata[LANE_LO +: 8];
            else if (reg_we && reg_addr == RA_EN_CLR) en_q <= en_q & ~reg_wdata[LANE_LO +: 8];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_DESC:   reg_rdata = desc_q;
            RA_STAT:   reg_rdata = {28'b0, err_q, done_q, valid_q, ~busy_i};
            RA_IRQ:    reg_rdata[LANE_LO +: 8] = lane_q;
            RA_EN_SET,
            RA_EN_CLR: reg_rdata[LANE_LO +: 8] = en_q;
            default:   ;
        endcase
    end

    assign irq_o = |(lane_q & en_q);

endmodule

// File: rtl/lut_refill_engine.sv
module lut_refill_engine
    import lrf_pkg::*;
#(
    parameter  int LUT_WIDTH  = 16,
    parameter  int LUT_HEIGHT = 8,
    parameter  int LANE       = 0,
    localparam int LUT_AW     = $clog2(LUT_WIDTH * LUT_HEIGHT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              lut_we,
    output logic [LUT_AW-1:0] lut_addr,
    output logic [31:0]       lut_wdata,
    output logic [3:0]        lut_id,
    output logic              irq
);

    logic        seq_busy;
    logic        seq_start;
    logic        seq_abort;
    logic [31:0] seq_ptr;
    seq_evt_t    seq_evt;

    lrf_regs #(.LANE(LANE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (seq_busy),
        .evt_i      (seq_evt),
        .start_o    (seq_start),
        .start_ptr_o(seq_ptr),
        .abort_o    (seq_abort),
        .irq_o      (irq)
    );

    lrf_seq #(
        .LUT_WIDTH (LUT_WIDTH),
        .LUT_HEIGHT(LUT_HEIGHT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (seq_start),
        .start_ptr_i(seq_ptr),
        .abort_i    (seq_abort),
        .mem_req_o  (mem_req),
        .mem_addr_o (mem_addr),
        .mem_ack_i  (mem_ack),
        .mem_rdata_i(mem_rdata),
        .mem_err_i  (mem_err),
        .lut_we_o   (lut_we),
        .lut_addr_o (lut_addr),
        .lut_wdata_o(lut_wdata),
        .lut_id_o   (lut_id),
        .busy_o     (seq_busy),
        .evt_o      (seq_evt)
    );

endmodule

// File: rtl/lrf_checker.sv
module lrf_checker
    import lrf_pkg::*;
#(
    parameter  int LUT_WIDTH  = 16,
    parameter  int LUT_HEIGHT = 8,
    localparam int AW = $clog2(LUT_WIDTH * LUT_HEIGHT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          mem_req,
    input logic [31:0]   mem_addr,
    input logic          mem_ack,
    input logic          lut_we,
    input logic [AW-1:0] lut_addr,
    input logic          busy
);

    logic ptr_wr, abort_wr, start_wr;
    assign ptr_wr   = reg_we && (reg_addr == RA_DESC);
    assign abort_wr = ptr_wr && (reg_wdata == '0);
    assign start_wr = ptr_wr && (reg_wdata != '0) && (reg_wdata[3:0] == 4'h0) && !busy;

    assert_start_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> busy && mem_req && (mem_addr == $past(reg_wdata)));

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr |=> !mem_req && !lut_we && !busy);

    assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort_wr) |=> mem_req && $stable(mem_addr));

    assert_word_aligned_R14: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_slot_in_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |-> (int'(lut_addr) < LUT_WIDTH * LUT_HEIGHT) && busy);

    assert_write_per_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |=> !lut_we);

endmodule

bind lut_refill_engine lrf_checker #(
    .LUT_WIDTH (LUT_WIDTH),
    .LUT_HEIGHT(LUT_HEIGHT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .lut_we   (lut_we),
    .lut_addr (lut_addr),
    .busy     (seq_busy)
);

// File: tb/sim_lut_refill_engine.sv
`timescale 1ns/1ps
module sim_lut_refill_engine;

    localparam int LW = 16;
    localparam int LH = 8;
    localparam int LN = 1;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          mem_err = 1'b0;
    logic          lut_we;
    logic [AW-1:0] lut_addr;
    logic [31:0]   lut_wdata;
    logic [3:0]    lut_id;
    logic          irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:1023];
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic [31:0] mr_log [0:255];
    int          mr_cnt = 0;
    logic [31:0] lw_addr [0:255];
    logic [31:0] lw_data [0:255];
    logic [3:0]  lw_id   [0:255];
    int          lw_cnt = 0;

    lut_refill_engine #(.LUT_WIDTH(LW), .LUT_HEIGHT(LH), .LANE(LN)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .lut_we(lut_we), .lut_addr(lut_addr),
        .lut_wdata(lut_wdata), .lut_id(lut_id), .irq(irq)
    );

    initial forever #2 clk = ~clk;

    // Memory responder: one-cycle acknowledge, optional fault address
    initial forever begin
        @(negedge clk);
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[11:2]];
            mem_err   = err_en && (mem_addr == err_addr);
            if (mr_cnt < 256) mr_log[mr_cnt] = mem_addr;
            mr_cnt++;
        end
    end

    // Table write logger
    initial forever begin
        @(negedge clk);
        if (lut_we) begin
            if (lw_cnt < 256) begin
                lw_addr[lw_cnt] = 32'(lut_addr);
                lw_data[lw_cnt] = lut_wdata;
                lw_id[lw_cnt]   = lut_id;
            end
            lw_cnt++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_rd(3'd1, s);
            if (s[0]) break;
        end
    endtask

    task automatic put_desc(input int base, input int x0, input int y0, input int x1,
                            input int y1, input logic [31:0] ctrl,
                            input logic [31:0] nxt, input logic [31:0] dptr);
        mem[(base >> 2) + 0] = {16'(y0), 16'(x0)};
        mem[(base >> 2) + 1] = {16'(y1), 16'(x1)};
        mem[(base >> 2) + 2] = ctrl;
        mem[(base >> 2) + 3] = nxt;
        mem[(base >> 2) + 4] = dptr;
    endtask

    task automatic fresh();
        reg_wr(3'd2, 32'hFFFF_FFFF);
        lw_cnt = 0;
        mr_cnt = 0;
    endtask

    function automatic logic [31:0] lane(input logic [7:0] b);
        return 32'(b) << (8 * LN);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(3'd1, v); chk("R1 status after reset", v, 32'h1);
        reg_rd(3'd2, v); chk("R1 irq lane after reset", v, 32'h0);
        reg_rd(3'd3, v); chk("R1 enables after reset", v, 32'h0);
        chk("R1 irq/req/we low", {29'b0, irq, mem_req, lut_we}, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        fresh();
        put_desc(32'h100, 2, 1, 4, 2, 32'h51, 32'h0, 32'h200);
        for (int k = 0; k < 6; k++) mem[(32'h200 >> 2) + k] = 32'hA000_0000 + k;
        reg_wr(3'd0, 32'h100);
        #1;
        chk("R3 request at pointer", {mem_req, mem_addr[30:0]}, {1'b1, 31'h100});
        reg_rd(3'd1, v); chk("R3 ready drops", {31'b0, v[0]}, 32'h0);
        wait_ready();
        for (int k = 0; k < 5; k++) chk("R3 descriptor word order", mr_log[k], 32'h100 + 4 * k);
        chk("R5 first data read", mr_log[5], 32'h200);
        chk("R5 write count", lw_cnt, 6);
        for (int k = 0; k < 6; k++) begin
            chk("R5 R4 row-major slot", lw_addr[k], (1 + k / 3) * LW + 2 + (k % 3));
            chk("R5 entry data", lw_data[k], 32'hA000_0000 + k);
            chk("R4 table id", 32'(lw_id[k]), 32'h5);
        end
        reg_rd(3'd1, v); chk("R6 status after chain", v, 32'h7);
        reg_rd(3'd2, v); chk("R6 R7 lane bits", v, lane(8'h90));
        reg_rd(3'd0, v); chk("R2 pointer readback", v, 32'h100);
        chk("R13 irq masked", 32'(irq), 0);
        reg_wr(3'd3, lane(8'h10));
        #1; chk("R13 irq on enable", 32'(irq), 1);
        reg_wr(3'd2, 32'h0000_0090 << (8 * ((LN + 1) % 4)));
        reg_rd(3'd2, v); chk("R13 other-lane clear ignored", v, lane(8'h90));
        reg_wr(3'd2, lane(8'h10));
        reg_rd(3'd2, v); chk("R13 write-one clear", v, lane(8'h80));
        chk("R13 irq drops", 32'(irq), 0);
        reg_wr(3'd3, lane(8'h80));
        #1; chk("R13 irq fill enabled", 32'(irq), 1);
        reg_wr(3'd4, lane(8'h90));
        reg_rd(3'd4, v); chk("R13 enables cleared", v, 32'h0);
        chk("R13 irq off", 32'(irq), 0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        fresh();
        put_desc(32'h300, 0, 0, 1, 0, 32'h31, 32'h320, 32'h380);
        put_desc(32'h320, 5, 5, 5, 5, 32'h30, 32'h340, 32'h390);
        put_desc(32'h340, 15, 7, 15, 7, 32'h21, 32'h0, 32'h3A0);
        mem[32'h380 >> 2] = 32'hB0; mem[(32'h380 >> 2) + 1] = 32'hB1;
        mem[32'h390 >> 2] = 32'hEE; mem[32'h3A0 >> 2] = 32'hC0;
        reg_wr(3'd0, 32'h300);
        wait_ready();
        chk("R6 R8 chain write count", lw_cnt, 3);
        chk("R6 slot 0", {lw_addr[0][23:0], lw_data[0][7:0]}, {24'd0, 8'hB0});
        chk("R6 slot 1", {lw_addr[1][23:0], lw_data[1][7:0]}, {24'd1, 8'hB1});
        chk("R6 far corner slot", {lw_addr[2][23:0], lw_data[2][7:0]}, {24'(7 * LW + 15), 8'hC0});
        chk("R8 id of third", 32'(lw_id[2]), 32'h2);
        reg_rd(3'd1, v); chk("R6 status", v, 32'h7);
        reg_rd(3'd2, v); chk("R7 lane", v, lane(8'h90));
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int snap;
        fresh();
        put_desc(32'h400, 0, 0, 15, 7, 32'h01, 32'h0, 32'h600);
        for (int k = 0; k < 128; k++) mem[(32'h600 >> 2) + k] = 32'hD000 + k;
        reg_wr(3'd0, 32'h400);
        repeat (30) @(negedge clk);
        reg_wr(3'd0, 32'h0);
        reg_rd(3'd1, v); chk("R9 status after abort", v, 32'h1);
        reg_rd(3'd0, v); chk("R9 pointer zero", v, 32'h0);
        snap = lw_cnt;
        chk("R9 partial walk", 32'((snap > 0) && (snap < 128)), 1);
        repeat (40) @(negedge clk);
        chk("R9 no writes after abort", lw_cnt, snap);
        chk("R9 no request", 32'(mem_req), 0);
        reg_rd(3'd2, v); chk("R9 no lane bits", v, 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        fresh();
        reg_wr(3'd0, 32'h100);
        reg_wr(3'd0, 32'h300);
        reg_rd(3'd0, v); chk("R10 pointer unchanged", v, 32'h100);
        wait_ready();
        chk("R10 chain unchanged", lw_cnt, 6);
        chk("R10 last entry", lw_data[5], 32'hA000_0005);
        reg_rd(3'd1, v); chk("R10 status", v, 32'h7);
    endtask

    task automatic t_bad_start();
        logic [31:0] v;
        fresh();
        reg_wr(3'd0, 32'h104);
        repeat (4) @(negedge clk);
        reg_rd(3'd1, v); chk("R11 misaligned start status", v, 32'h9);
        reg_rd(3'd2, v); chk("R11 misaligned start lane", v, lane(8'h02));
        chk("R11 no reads", mr_cnt, 0);
    endtask

    task automatic t_bad_rect();
        logic [31:0] v;
        fresh();
        put_desc(32'h800, 3, 0, 2, 0, 32'h01, 32'h0, 32'h900);
        reg_wr(3'd0, 32'h800);
        wait_ready();
        reg_rd(3'd1, v); chk("R11 inverted rect status", v, 32'h9);
        reg_rd(3'd2, v); chk("R11 inverted rect lane", v, lane(8'h02));
        chk("R11 no writes", lw_cnt, 0);
        fresh();
        put_desc(32'h820, 0, 0, 16, 0, 32'h01, 32'h0, 32'h900);
        reg_wr(3'd0, 32'h820);
        wait_ready();
        reg_rd(3'd1, v); chk("R11 outside table status", v, 32'h9);
        chk("R11 outside no writes", lw_cnt, 0);
        fresh();
        put_desc(32'h840, 0, 0, 0, 0, 32'h01, 32'h868, 32'h8A0);
        mem[32'h8A0 >> 2] = 32'h77;
        reg_wr(3'd0, 32'h840);
        wait_ready();
        chk("R11 bad link after one write", lw_cnt, 1);
        reg_rd(3'd1, v); chk("R11 bad link status", v, 32'h9);
        reg_rd(3'd2, v); chk("R11 R7 bad link lane", v, lane(8'h82));
    endtask

    task automatic t_mem_err();
        logic [31:0] v;
        fresh();
        err_en = 1'b1; err_addr = 32'h208;
        reg_wr(3'd0, 32'h100);
        wait_ready();
        err_en = 1'b0;
        chk("R12 writes before fault", lw_cnt, 2);
        reg_rd(3'd1, v); chk("R12 status", v, 32'h9);
        reg_rd(3'd2, v); chk("R12 lane", v, lane(8'h04));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_abort();
        t_busy_ignore();
        t_bad_start();
        t_bad_rect();
        t_mem_err();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule